// File: doc/BRIEF.md
# Lookup-table DAC code selector

This block picks the 8-bit code for each of two current-output DAC channels and the polarity flag that goes with it. Each channel owns a 64-entry byte table. A channel's code comes from one of three places. It can come from the table row chosen by the upper six bits of the 8-bit ADC temperature reading. It can come from the table row named in the channel's control register. Or it can be a plain byte held in a register. Both the chosen code and the polarity flag are held in registers, so the converters downstream always see stable values.

All state is written through a parallel byte port that has a write strobe. There is no read path. Software fills the tables, sets each channel's control byte and direction bits, and after that the codes follow the ADC reading on their own, or stay fixed when a channel is set to row or direct mode.

Top module: `lut_dac_sel`

## Requirements
- R1: After reset both codes are 0x00, both sink flags are 0, all control and direct bytes are 0, and every table entry is 0x00.
- R2: When bit 7 and bit 6 of a channel's control byte are both 0, its code is the entry of its own table at the row given by adc_code[7:2].
- R3: When bit 7 is 0 and bit 6 is 1, the code is the table entry at the row in control bits [5:0], and the ADC reading has no effect on it.
- R4: When bit 7 of the control byte is 1, the code is the channel's direct byte, whatever bit 6 holds.
- R5: A code changes exactly one clock edge after its source changes (ADC reading, control byte, direct byte or table entry), and not before.
- R6: A write to address 0x80 sets ch0_sink from data bit 0 and ch1_sink from data bit 1, both visible right after the write edge (0 = source, 1 = sink).
- R7: A write to a table row that is currently selected shows on that channel's code one edge after the write edge.
- R8: Address map: 0x00–0x3F write table 0 (row = addr[5:0]), 0x40–0x7F write table 1, 0x81/0x82 are the control bytes of ch0/ch1, and 0x83/0x84 are the direct bytes of ch0/ch1. The two channels never affect each other.
- R9: Writes to addresses 0x85–0xFF change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| adc_code | input | 8 | ADC temperature reading |
| ch0_code | output | 8 | Registered DAC code, channel 0 |
| ch1_code | output | 8 | Registered DAC code, channel 1 |
| ch0_sink | output | 1 | Channel 0 polarity, 1 = sink |
| ch1_sink | output | 1 | Channel 1 polarity, 1 = sink |

## Verification
A table write and a change of the ADC reading can land on the same clock edge. The bench provokes this by writing the row the ADC is leaving while moving the ADC to a different row, and also by writing the row the ADC is arriving at. In the first case the next code must be the new row's old contents, and the written value shows only after the ADC returns to that row. In the second case the code first takes the pre-write entry for one edge and then the written value on the following edge.

// File: rtl/lut_dac_sel.sv
module lut_dac_sel #(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [CODE_W-1:0] adc_code,
  output logic [CODE_W-1:0] ch0_code,
  output logic [CODE_W-1:0] ch1_code,
  output logic              ch0_sink,
  output logic              ch1_sink
);
  localparam int ROWS = 1 << ROW_W;
  localparam int BIT_DIRECT = CODE_W - 1;
  localparam int BIT_TABLE  = CODE_W - 2;
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'(8'h81);
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(8'h82);
  localparam logic [ADDR_W-1:0] A_DB0  = ADDR_W'(8'h83);
  localparam logic [ADDR_W-1:0] A_DB1  = ADDR_W'(8'h84);

  logic [CODE_W-1:0] lut0 [ROWS];
  logic [CODE_W-1:0] lut1 [ROWS];
  logic [CODE_W-1:0] ctl0, ctl1, dbyte0, dbyte1;
  logic [1:0]        dir_q;

  wire [ROW_W-1:0] adc_row = adc_code[CODE_W-1 -: ROW_W];
  wire [ROW_W-1:0] waddr_row = wr_addr[ROW_W-1:0];
  wire in_tables = (wr_addr >> (ROW_W + 1)) == '0;
  wire hit_t0 = wr_en && in_tables && !wr_addr[ROW_W];
  wire hit_t1 = wr_en && in_tables &&  wr_addr[ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        lut0[i] <= '0;
        lut1[i] <= '0;
      end
    end else begin
      if (hit_t0) lut0[waddr_row] <= wr_data;
      if (hit_t1) lut1[waddr_row] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0; dbyte0 <= '0; dbyte1 <= '0; dir_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIR:  dir_q  <= wr_data[1:0];
        A_CTL0: ctl0   <= wr_data;
        A_CTL1: ctl1   <= wr_data;
        A_DB0:  dbyte0 <= wr_data;
        A_DB1:  dbyte1 <= wr_data;
        default: ;
      endcase
    end
  end

  wire [ROW_W-1:0] row0 = ctl0[BIT_TABLE] ? ctl0[ROW_W-1:0] : adc_row;
  wire [ROW_W-1:0] row1 = ctl1[BIT_TABLE] ? ctl1[ROW_W-1:0] : adc_row;
  wire [CODE_W-1:0] nxt0 = ctl0[BIT_DIRECT] ? dbyte0 : lut0[row0];
  wire [CODE_W-1:0] nxt1 = ctl1[BIT_DIRECT] ? dbyte1 : lut1[row1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch0_code <= '0;
      ch1_code <= '0;
    end else begin
      ch0_code <= nxt0;
      ch1_code <= nxt1;
    end
  end

  assign ch0_sink = dir_q[0];
  assign ch1_sink = dir_q[1];
endmodule

// File: rtl/lut_dac_sel_chk.sv
module lut_dac_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] adc_code,
  input logic [7:0] ch0_code,
  input logic [7:0] ch1_code,
  input logic       ch0_sink,
  input logic       ch1_sink,
  input logic [7:0] ctl0,
  input logic [7:0] ctl1,
  input logic [7:0] dbyte0,
  input logic [7:0] dbyte1,
  input logic [7:0] lut0 [64],
  input logic [7:0] lut1 [64]
);
  a_r2_adc_row0: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl0[7] && !ctl0[6]) |=> ch0_code == $past(lut0[adc_code[7:2]]));

  a_r3_reg_row1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1[7] && ctl1[6]) |=> ch1_code == $past(lut1[ctl1[5:0]]));

  a_r4_direct0: assert property (@(posedge clk) disable iff (!rst_n)
    ctl0[7] |=> ch0_code == $past(dbyte0));

  a_r4_direct1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1[7] |=> ch1_code == $past(dbyte1));

  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h80) |=> (ch0_sink == $past(wr_data[0]) && ch1_sink == $past(wr_data[1])));

  a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 8'h80) |=> ($stable(ch0_sink) && $stable(ch1_sink)));
endmodule

bind lut_dac_sel lut_dac_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .adc_code(adc_code), .ch0_code(ch0_code), .ch1_code(ch1_code),
  .ch0_sink(ch0_sink), .ch1_sink(ch1_sink), .ctl0(ctl0), .ctl1(ctl1),
  .dbyte0(dbyte0), .dbyte1(dbyte1), .lut0(lut0), .lut1(lut1)
);

// File: tb/lut_dac_sel_bench.sv
module lut_dac_sel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, adc_code = '0;
  logic [7:0] ch0_code, ch1_code;
  logic ch0_sink, ch1_sink;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lut_dac_sel u_lut_dac_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .adc_code(adc_code), .ch0_code(ch0_code), .ch1_code(ch1_code),
    .ch0_sink(ch0_sink), .ch1_sink(ch1_sink)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ch0_code", ch0_code, 8'h00);
    chk("R1 ch1_code", ch1_code, 8'h00);
    chk("R1 sinks", {6'd0, ch1_sink, ch0_sink}, 8'h00);
  endtask

  task automatic t_adc();
    wr(8'h0A, 8'h3C); wr(8'h0B, 8'h5A); wr(8'h4A, 8'hA5);
    @(negedge clk); adc_code = 8'h28; settle();
    chk("R2 R8 ch0 row10", ch0_code, 8'h3C);
    chk("R2 R8 ch1 row10", ch1_code, 8'hA5);
    adc_code = 8'h2F; settle();
    chk("R2 ch0 row11", ch0_code, 8'h5A);
    chk("R2 R8 ch1 row11", ch1_code, 8'h00);
    adc_code = 8'h28; #1;
    chk("R5 no early change", ch0_code, 8'h5A);
    settle();
    chk("R5 one edge later", ch0_code, 8'h3C);
  endtask

  task automatic t_row();
    wr(8'h81, 8'h4B); settle();
    chk("R3 ch0 reg row", ch0_code, 8'h5A);
    adc_code = 8'h00; settle();
    chk("R3 adc ignored", ch0_code, 8'h5A);
    wr(8'h82, 8'h4A); settle();
    chk("R3 ch1 reg row", ch1_code, 8'hA5);
    adc_code = 8'h28;
  endtask

  task automatic t_direct();
    wr(8'h83, 8'hE7); wr(8'h81, 8'hCB); settle();
    chk("R4 ch0 direct with table bit", ch0_code, 8'hE7);
    wr(8'h84, 8'h19); wr(8'h82, 8'h80); settle();
    chk("R4 ch1 direct", ch1_code, 8'h19);
    chk("R8 ch0 independent", ch0_code, 8'hE7);
    wr(8'h81, 8'h00); settle();
    chk("R2 back to adc mode", ch0_code, 8'h3C);
  endtask

  task automatic t_dir();
    wr(8'h80, 8'h01);
    chk("R6 sinks 01", {6'd0, ch1_sink, ch0_sink}, 8'h01);
    wr(8'h80, 8'h02);
    chk("R6 sinks 10", {6'd0, ch1_sink, ch0_sink}, 8'h02);
  endtask

  task automatic t_lutwr();
    wr(8'h82, 8'h4A); settle();
    chk("R3 ch1 row10", ch1_code, 8'hA5);
    wr(8'h4A, 8'h77);
    chk("R7 write edge old value", ch1_code, 8'hA5);
    settle();
    chk("R7 new value", ch1_code, 8'h77);
  endtask

  task automatic t_same();
    @(negedge clk); adc_code = 8'h2C; wr_en = 1'b1; wr_addr = 8'h0A; wr_data = 8'h11;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    chk("R7 leave row: new row", ch0_code, 8'h5A);
    adc_code = 8'h28; settle();
    chk("R7 return sees write", ch0_code, 8'h11);
    adc_code = 8'h2C; wr_en = 1'b1; wr_addr = 8'h0B; wr_data = 8'h22;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    chk("R5 arrive row: old entry", ch0_code, 8'h5A);
    settle();
    chk("R7 arrive row: written", ch0_code, 8'h22);
  endtask

  task automatic t_ignore();
    wr(8'h82, 8'h40); settle();
    chk("R3 ch1 row0", ch1_code, 8'h00);
    wr(8'hC0, 8'hFF); wr(8'h90, 8'h03); wr(8'hFF, 8'hFF); wr(8'h85, 8'hC0);
    settle();
    chk("R9 ch1 unchanged", ch1_code, 8'h00);
    chk("R9 ch0 unchanged", ch0_code, 8'h22);
    chk("R9 sinks unchanged", {6'd0, ch1_sink, ch0_sink}, 8'h02);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_adc();
    t_row();
    t_direct();
    t_dir();
    t_lutwr();
    t_same();
    t_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule